// File: doc/BRIEF.md
# Shared RAM Mode and Handoff Register

This block is the main-processor copy of a memory mode register that sits between a main CPU and a sub CPU sharing a work RAM. Its low byte picks which 128 KB bank of program RAM shows through the main CPU's window. It also carries the ownership handshake for the shared RAM. In whole-RAM mode the main CPU hands the RAM to the sub CPU. In split mode the main CPU can instead ask for a swap back.

A write from the main side is either a byte write, which touches only the low byte, or a word write, which also loads an 8-bit write-protect field in the high byte. The sharing mode bit and the return-bit set request come from the sub side as plain inputs. The register turns each accepted handoff into a one-cycle request pulse. When the sub CPU is stalled waiting for the shared RAM, it also issues a one-cycle wake pulse.

Top module: `shram_mode_reg`

## Requirements
- R1: After reset the bank is 0, the write-protect field is 0, the handoff flag (rd_data bit 1) is 0, the return bit (rd_data bit 0) is 1, and handoff_req, sub_wake and swap_pending are all 0.
- R2: Any write loads the bank from wr_data bits 7:6. The bank appears in rd_data bits 7:6 and on bank_sel, and bank_offset equals the bank shifted left by 17.
- R3: rd_data bits 5:3 always read 0, and rd_data bit 2 always mirrors the sub_mode_1m input (1 = split mode, 0 = whole mode).
- R4: A word write loads the write-protect field (wp and rd_data bits 15:8) from wr_data bits 15:8. A byte write leaves that field unchanged. When both strobes are high, the write is treated as a word write.
- R5: In whole mode, a write with wr_data bit 1 = 0 leaves the handoff flag and the return bit unchanged and raises no pulse.
- R6: In whole mode, a write with wr_data bit 1 = 1 sets the handoff flag and clears the return bit. handoff_req is then high for exactly the cycle after that write.
- R7: sub_wake is high in the same cycle as the handoff_req pulse when sub_waiting was high during the handing-off write, and it is low at all other times.
- R8: In split mode, a write with wr_data bit 1 = 0 sets the handoff flag, leaves the return bit unchanged and raises no handoff_req.
- R9: In split mode, a write with wr_data bit 1 = 1 leaves the handoff flag and the return bit unchanged and sets swap_pending. swap_pending clears on the cycle after any cycle in which sub_mode_1m is 0.
- R10: sub_ret_set sets the return bit and clears the handoff flag on the next cycle. If a main write in the same cycle sets the handoff flag (R6 or R8), that write wins and sub_ret_set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_byte | input | 1 | Main-side byte write strobe (low byte only) |
| wr_word | input | 1 | Main-side word write strobe |
| wr_data | input | 16 | Main-side write data |
| sub_mode_1m | input | 1 | Sharing mode from the sub side: 1 = split, 0 = whole |
| sub_ret_set | input | 1 | Sub side returns the RAM: sets the return bit |
| sub_waiting | input | 1 | Sub CPU is stalled waiting for shared RAM |
| rd_data | output | 16 | Main-side read value, with bits 5:3 masked to 0 |
| bank_sel | output | 2 | Program-RAM bank number |
| bank_offset | output | 19 | Byte offset of the selected bank |
| wp | output | 8 | Write-protect field |
| handoff_req | output | 1 | One-cycle pulse per accepted whole-mode handoff |
| sub_wake | output | 1 | One-cycle pulse that releases a stalled sub CPU |
| swap_pending | output | 1 | Latched split-mode swap request |

## Verification
The two functions that can fall in one cycle are a main-side write that sets the handoff flag and a sub-side return request. The sweep asserts sub_ret_set alongside every write, in both modes and with both values of bit 1. It then compares the flag and the return bit with a bench model in which the main write takes priority. The same sweep pairs sub_waiting with every handoff, to judge that the wake pulse lines up with the request pulse and never appears without it.

// File: rtl/shram_mode_reg.sv
module shram_mode_reg #(
  parameter int WP_W       = 8,
  parameter int BANK_SHIFT = 17,
  localparam int RD_W      = WP_W + 8,
  localparam int OFS_W     = BANK_SHIFT + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte,
  input  logic             wr_word,
  input  logic [RD_W-1:0]  wr_data,
  input  logic             sub_mode_1m,
  input  logic             sub_ret_set,
  input  logic             sub_waiting,
  output logic [RD_W-1:0]  rd_data,
  output logic [1:0]       bank_sel,
  output logic [OFS_W-1:0] bank_offset,
  output logic [WP_W-1:0]  wp,
  output logic             handoff_req,
  output logic             sub_wake,
  output logic             swap_pending
);

  logic [1:0]      bank_q;
  logic [WP_W-1:0] wp_q;
  logic            own_q, ret_q, swap_q, hand_q, wake_q;

  logic wr_any, give, set_split, swap_hit, main_sets, ret_take;

  assign wr_any    = wr_byte | wr_word;
  assign give      = wr_any & ~sub_mode_1m &  wr_data[1];
  assign set_split = wr_any &  sub_mode_1m & ~wr_data[1];
  assign swap_hit  = wr_any &  sub_mode_1m &  wr_data[1];
  assign main_sets = give | set_split;
  assign ret_take  = sub_ret_set & ~main_sets;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      wp_q   <= '0;
      own_q  <= 1'b0;
      ret_q  <= 1'b1;
      swap_q <= 1'b0;
      hand_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (wr_any)  bank_q <= wr_data[7:6];
      if (wr_word) wp_q   <= wr_data[RD_W-1:8];
      if (main_sets)     own_q <= 1'b1;
      else if (ret_take) own_q <= 1'b0;
      if (give)          ret_q <= 1'b0;
      else if (ret_take) ret_q <= 1'b1;
      if (!sub_mode_1m)  swap_q <= 1'b0;
      else if (swap_hit) swap_q <= 1'b1;
      hand_q <= give;
      wake_q <= give & sub_waiting;
    end
  end

  assign rd_data      = {wp_q, bank_q, 3'b000, sub_mode_1m, own_q, ret_q};
  assign bank_sel     = bank_q;
  assign bank_offset  = OFS_W'(bank_q) << BANK_SHIFT;
  assign wp           = wp_q;
  assign handoff_req  = hand_q;
  assign sub_wake     = wake_q;
  assign swap_pending = swap_q;

  AST_HANDOFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_req |-> $past((wr_byte | wr_word) & ~sub_mode_1m & wr_data[1])); // R6
  AST_HANDOFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_req |-> (rd_data[1] && !rd_data[0])); // R6
  AST_WAKE_WITH_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    sub_wake |-> handoff_req); // R7
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_word) |-> (wp == $past(wp))); // R4
  AST_WHOLE_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past((wr_byte | wr_word) & ~sub_mode_1m & ~wr_data[1] & ~sub_ret_set)
      |-> (rd_data[1:0] == $past(rd_data[1:0]))); // R5
  AST_SPLIT_ZERO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past((wr_byte | wr_word) & sub_mode_1m & ~wr_data[1]) |-> (rd_data[1] && !handoff_req)); // R8
  AST_SWAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sub_mode_1m) |-> !swap_pending); // R9

endmodule

// File: tb/test_shram_mode_reg.sv
module test_shram_mode_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_byte = 1'b0, wr_word = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sub_mode_1m = 1'b0, sub_ret_set = 1'b0, sub_waiting = 1'b0;
  logic [15:0] rd_data;
  logic [1:0]  bank_sel;
  logic [18:0] bank_offset;
  logic [7:0]  wp;
  logic        handoff_req, sub_wake, swap_pending;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [1:0] m_bank;
  logic [7:0] m_wp;
  logic       m_own, m_ret, m_swap, m_hand, m_wake;

  shram_mode_reg i_shram_mode_reg (
    .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .wr_word(wr_word), .wr_data(wr_data),
    .sub_mode_1m(sub_mode_1m), .sub_ret_set(sub_ret_set), .sub_waiting(sub_waiting),
    .rd_data(rd_data), .bank_sel(bank_sel), .bank_offset(bank_offset), .wp(wp),
    .handoff_req(handoff_req), .sub_wake(sub_wake), .swap_pending(swap_pending));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tg);
    chk("R2 bank", int'(rd_data[7:6]), int'(m_bank));
    chk("R2 bank_sel", int'(bank_sel), int'(m_bank));
    chk("R2 offset", int'(bank_offset), int'(m_bank) * 131072);
    chk("R3 mask", int'(rd_data[5:2]), int'(sub_mode_1m));
    chk("R4 wp", int'(rd_data[15:8]), int'(m_wp));
    chk("R4 wp port", int'(wp), int'(m_wp));
    chk({tg, " flag/ret"}, int'(rd_data[1:0]), int'({m_own, m_ret}));
    chk("R6 handoff_req", int'(handoff_req), int'(m_hand));
    chk("R7 sub_wake", int'(sub_wake), int'(m_wake));
    chk("R9 swap_pending", int'(swap_pending), int'(m_swap));
  endtask

  task automatic step(input bit b, input bit w, input logic [15:0] d, input bit md,
                      input bit sr, input bit wt);
    bit any, give, s0, s1, take;
    string tg;
    wr_byte = b; wr_word = w; wr_data = d;
    sub_mode_1m = md; sub_ret_set = sr; sub_waiting = wt;
    any  = b | w;
    give = any && !md && d[1];
    s0   = any && md && !d[1];
    s1   = any && md && d[1];
    take = sr && !(give || s0);
    tg = give ? "R6" : s0 ? "R8" : s1 ? "R9" : any ? "R5" : "R10";
    if (sr) tg = {tg, "/R10"};
    if (any) m_bank = d[7:6];
    if (w)   m_wp   = d[15:8];
    if (give || s0) m_own = 1'b1; else if (take) m_own = 1'b0;
    if (give) m_ret = 1'b0; else if (take) m_ret = 1'b1;
    if (!md) m_swap = 1'b0; else if (s1) m_swap = 1'b1;
    m_hand = give;
    m_wake = give && wt;
    @(posedge clk);
    @(negedge clk);
    compare(tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_bank = 0; m_wp = 0; m_own = 0; m_ret = 1; m_swap = 0; m_hand = 0; m_wake = 0;
    chk("R1 reset rd_data", int'(rd_data), 16'h0001);
    chk("R1 reset pulses", int'({handoff_req, sub_wake, swap_pending}), 0);
    compare("R1");
    for (int md = 1; md >= 0; md--)
      for (int k = 0; k < 3; k++)
        for (int d = 0; d < 256; d++)
          for (int sr = 0; sr < 2; sr++)
            for (int wt = 0; wt < 2; wt++) begin
              step(k == 0, k != 0, {8'(d) ^ 8'h5A, 8'(d)}, md[0], sr[0], wt[0]);
              if (d[0] && wt == 1) step(1'b0, 1'b0, 16'h0, md[0], 1'b1, 1'b0);
              if (d[2] && sr == 0) step(1'b0, 1'b0, 16'h0, md[0], 1'b0, 1'b1);
            end
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule